// File: doc/BRIEF.md
# Column Burst Sequencer with Clock Suspend

This block is the column side of a behavioural synchronous DRAM model. A READ or WRITE command starts a burst at a given column. The block then steps a burst counter over the following clock edges and visits the columns of the burst in sequence, wrapping inside a block of columns aligned to the burst length. Write beats store the word on the write-data input into a small register-file array. Read beats fetch a word from the array and present it on the read-data output a fixed CAS latency later, with a valid flag beside it.

A clock-enable input provides clock suspend. A low clock enable, sampled while a burst or read return is in progress, freezes the next internal edge. On that edge the counter, the array and the output register all keep their values, and any command or write data presented is dropped. Sampling the clock enable high lets the following edge run normally. While the block is idle, a low clock enable does nothing.

Top module: `burst_sus_eng`

## Requirements
- R1: After a synchronous active-low reset, rvalid is 0, rdata is 0, cur_col is 0 and every array word reads as 0.
- R2: The bl_sel code is taken with the command and sets the burst length: 2'b00 gives 1 beat, 2'b01 gives 2, 2'b10 gives 4, 2'b11 gives 8. A read burst returns exactly that many valid beats when it is not suspended.
- R3: Beat k of a burst that starts at column S with length L uses a column whose bits above log2(L) equal those of S and whose low log2(L) bits equal (S + k) mod L. cur_col shows the column used on the latest unsuspended burst edge.
- R4: On each unsuspended write beat edge, including the edge that carries the WRITE (cmd 2'b10), the word on wdata is stored at that beat's column.
- R5: A read beat used on edge t, with READ being cmd 2'b01, appears on rdata with rvalid high after edge t+CAS_LAT (default 2), provided no edge in between is suspended. rdata is 0 whenever rvalid is low.
- R6: If cke is low at edge t and, after that edge, a burst beat remains or read data is still pending or on rdata, then edge t+1 is suspended: cur_col, rdata and rvalid do not change, and the counter does not advance.
- R7: On a suspended edge, cmd and wdata are ignored and the array is not written. The pending write column is written on the next unsuspended edge with the wdata present then.
- R8: A low cke while no burst is active and no read data is pending has no effect, so a command on the next edge is accepted.
- R9: With cke high at edge t, edge t+1 runs normally and the burst resumes where it stopped.
- R10: A READ or WRITE on an unsuspended edge during a burst drops the beats that remain and starts the new burst on that edge. cmd 2'b00 and 2'b11 are no-operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock enable; low requests suspension of the next edge |
| cmd | input | 2 | 00 none, 01 READ, 10 WRITE, 11 none |
| col | input | COL_W | Start column, taken with the command |
| wdata | input | DW | Write data for the current beat |
| bl_sel | input | 2 | Burst length code, taken with the command |
| rdata | output | DW | Read data, 0 when not valid |
| rvalid | output | 1 | Read data valid |
| cur_col | output | COL_W | Column used on the latest burst edge |

## Verification
Suspension and burst progress can meet on the same edge. A low clock enable can coincide with a new command, with the last beat of a burst, or with read data leaving the latency pipe. The bench provokes these directly: it suspends a write burst while presenting a stray WRITE and junk data, and it pulses the clock enable low in the middle of a read burst. It also runs a long random mix of commands, burst lengths and clock-enable values. An edge-by-edge reference model, built from the requirements, judges every cycle: it decides whether each edge was suspended and what the column, data and valid flag must then be. Array contents are confirmed afterwards by reading them back.

// File: rtl/bse_pkg.sv
// Package: shared command encoding and burst-length decode for the burst
// sequencer. Assumes burst lengths are powers of two up to 8.
package bse_pkg;

    typedef enum logic [1:0] {
        CMD_NOP   = 2'b00,
        CMD_READ  = 2'b01,
        CMD_WRITE = 2'b10,
        CMD_RSVD  = 2'b11
    } bse_cmd_e;

    // Burst length minus one for a 2-bit length code (0..7).
    function automatic logic [2:0] bse_len_m1(input logic [1:0] code);
        logic [3:0] len;
        len = 4'd1 << code;
        return 3'(len - 4'd1);
    endfunction

endpackage

// File: rtl/bse_col_ctr.sv
// Burst column counter. It loads a start column and length when a command
// is accepted and presents the column of each beat combinationally, wrapping
// inside the length-aligned block. All state holds while en is low.
// Assumes COL_W >= 3 so that an 8-beat wrap fits.
module bse_col_ctr
    import bse_pkg::*;
#(
    parameter int COL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             start,
    input  logic             start_wr,
    input  logic [COL_W-1:0] col_in,
    input  logic [1:0]       bl_code,
    output logic             acc,
    output logic             acc_wr,
    output logic [COL_W-1:0] acc_col,
    output logic             act,
    output logic [COL_W-1:0] cur_col
);

    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] mask_q;
    logic [2:0]       idx_q;
    logic [2:0]       last_q;
    logic             wr_q;

    // Column used this edge: command start column or next wrapped beat.
    always_comb begin
        acc     = 1'b0;
        acc_wr  = 1'b0;
        acc_col = cur_col;
        if (start) begin
            acc     = 1'b1;
            acc_wr  = start_wr;
            acc_col = col_in;
        end else if (act) begin
            acc     = 1'b1;
            acc_wr  = wr_q;
            acc_col = (base_q & ~mask_q) | ((base_q + COL_W'(idx_q)) & mask_q);
        end
    end

    // Burst state: load on command, step on each enabled beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            mask_q  <= '0;
            idx_q   <= '0;
            last_q  <= '0;
            wr_q    <= 1'b0;
            act     <= 1'b0;
            cur_col <= '0;
        end else if (en) begin
            if (start) begin
                base_q <= col_in;
                mask_q <= COL_W'(bse_len_m1(bl_code));
                last_q <= bse_len_m1(bl_code);
                idx_q  <= 3'd1;
                wr_q   <= start_wr;
                act    <= (bl_code != 2'b00);
            end else if (act) begin
                idx_q <= idx_q + 3'd1;
                if (idx_q == last_q) begin
                    act <= 1'b0;
                end
            end
            if (acc) begin
                cur_col <= acc_col;
            end
        end
    end

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        act |-> (idx_q != 3'd0 && idx_q <= last_q)); // R3

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(cur_col) && $stable(act)); // R6

endmodule

// File: rtl/bse_array.sv
// Register-file array. It writes one word on an enabled write and reads
// combinationally at any address. Assumes at most one write per edge;
// reset clears all words.
module bse_array #(
    parameter int COL_W = 4,
    parameter int DW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [COL_W-1:0] waddr,
    input  logic [DW-1:0]    wdata,
    input  logic [COL_W-1:0] raddr,
    output logic [DW-1:0]    rdata
);

    localparam int DEPTH = 1 << COL_W;

    logic [DW-1:0] mem [DEPTH];

    // Asynchronous read port.
    assign rdata = mem[raddr];

    // Storage update: clear on reset, single-word write otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    AST_WR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem[$past(waddr)] == $past(wdata)); // R4

endmodule

// File: rtl/bse_rd_pipe.sv
// Read latency pipe. A fetched word passes through CAS_LAT+1 register
// stages, so a word fetched on edge t shows after edge t+CAS_LAT. Every
// stage holds while en is low. Invalid stages carry zero data.
module bse_rd_pipe #(
    parameter int DW      = 8,
    parameter int CAS_LAT = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          in_v,
    input  logic [DW-1:0] in_d,
    output logic          out_v,
    output logic [DW-1:0] out_d,
    output logic          busy
);

    localparam int NST = CAS_LAT + 1;

    logic [NST-1:0] v_q;
    logic [DW-1:0]  d_q [NST];

    // Shift the pipe on each enabled edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q <= '0;
            for (int i = 0; i < NST; i++) begin
                d_q[i] <= '0;
            end
        end else if (en) begin
            v_q[0] <= in_v;
            d_q[0] <= in_v ? in_d : '0;
            for (int i = 1; i < NST; i++) begin
                v_q[i] <= v_q[i-1];
                d_q[i] <= d_q[i-1];
            end
        end
    end

    assign out_v = v_q[NST-1];
    assign out_d = d_q[NST-1];
    assign busy  = |v_q;

    AST_DQ_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !out_v |-> out_d == '0); // R5

endmodule

// File: rtl/burst_sus_eng.sv
// Top of the column burst sequencer. It samples cke each edge. The next
// internal edge is suspended when cke was low and a burst or read return is
// still in progress. A suspended edge freezes the counter, the array and the
// read pipe, and drops the command and write data.
// Assumes one command per edge and COL_W >= 3.
module burst_sus_eng
    import bse_pkg::*;
#(
    parameter int COL_W   = 4,
    parameter int DW      = 8,
    parameter int CAS_LAT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cke,
    input  logic [1:0]       cmd,
    input  logic [COL_W-1:0] col,
    input  logic [DW-1:0]    wdata,
    input  logic [1:0]       bl_sel,
    output logic [DW-1:0]    rdata,
    output logic             rvalid,
    output logic [COL_W-1:0] cur_col
);

    logic             cke_lo_q;
    logic             susp;
    logic             en;
    logic             cmd_go;
    logic             cmd_wr;
    logic             acc;
    logic             acc_wr;
    logic [COL_W-1:0] acc_col;
    logic             act;
    logic             pipe_busy;
    logic [DW-1:0]    arr_rd;

    // Capture the clock-enable pin on every edge, suspended or not.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cke_lo_q <= 1'b0;
        end else begin
            cke_lo_q <= ~cke;
        end
    end

    // Suspend only while column activity remains.
    assign susp   = cke_lo_q & (act | pipe_busy);
    assign en     = ~susp;
    assign cmd_go = (cmd == CMD_READ) || (cmd == CMD_WRITE);
    assign cmd_wr = (cmd == CMD_WRITE);

    bse_col_ctr #(.COL_W(COL_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .start    (cmd_go),
        .start_wr (cmd_wr),
        .col_in   (col),
        .bl_code  (bl_sel),
        .acc      (acc),
        .acc_wr   (acc_wr),
        .acc_col  (acc_col),
        .act      (act),
        .cur_col  (cur_col)
    );

    bse_array #(.COL_W(COL_W), .DW(DW)) u_arr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (acc & acc_wr & en),
        .waddr (acc_col),
        .wdata (wdata),
        .raddr (acc_col),
        .rdata (arr_rd)
    );

    bse_rd_pipe #(.DW(DW), .CAS_LAT(CAS_LAT)) u_pipe (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .in_v  (acc & ~acc_wr),
        .in_d  (arr_rd),
        .out_v (rvalid),
        .out_d (rdata),
        .busy  (pipe_busy)
    );

    AST_SUSP_FREEZE_COL: assert property (@(posedge clk) disable iff (!rst_n)
        susp |=> $stable(cur_col)); // R6

    AST_SUSP_HOLD_DQ: assert property (@(posedge clk) disable iff (!rst_n)
        susp |=> $stable(rdata) && $stable(rvalid)); // R6

    AST_CMD_LOADS_COL: assert property (@(posedge clk) disable iff (!rst_n)
        (!susp && cmd_go) |=> cur_col == $past(col)); // R10

    AST_IDLE_NO_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (!act && !pipe_busy && cmd_go) |=> cur_col == $past(col)); // R8

endmodule

// File: tb/burst_sus_eng_tb.sv
// Self-checking bench: directed corner cases plus seeded random stimulus,
// judged each cycle by an edge-level reference model built from the
// requirements.
module burst_sus_eng_tb;

    localparam int COL_W = 4;
    localparam int DW    = 8;
    localparam int CL    = 2;
    localparam int DEPTH = 1 << COL_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cke = 1'b1;
    logic [1:0]       cmd = 2'b00;
    logic [COL_W-1:0] col = '0;
    logic [DW-1:0]    wdata = '0;
    logic [1:0]       bl_sel = 2'b00;
    logic [DW-1:0]    rdata;
    logic             rvalid;
    logic [COL_W-1:0] cur_col;

    burst_sus_eng #(.COL_W(COL_W), .DW(DW), .CAS_LAT(CL)) u_dut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cmd(cmd), .col(col),
        .wdata(wdata), .bl_sel(bl_sel), .rdata(rdata), .rvalid(rvalid),
        .cur_col(cur_col)
    );

    always #5 clk = ~clk;

    int    n_chk = 0;
    int    n_err = 0;
    int    cyc   = 0;
    bit    run_cmp = 1'b0;
    string scen_tag = "R5";

    // Reference model state.
    logic [DW-1:0]    m_mem [DEPTH];
    logic             m_v [CL+1];
    logic [DW-1:0]    m_d [CL+1];
    logic             m_act, m_wr, m_cke_lo, m_susp;
    logic [COL_W-1:0] m_base, m_cur;
    int               m_len, m_idx;
    string            m_tag = "R5";

    // Captured read beats.
    logic [DW-1:0] cap [64];
    int            cap_n = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act_v, input int exp_v);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act_v, exp_v);
        end
    endtask

    function automatic logic [COL_W-1:0] wrap_col(input logic [COL_W-1:0] b,
                                                  input int k, input int len);
        logic [COL_W-1:0] m;
        m = COL_W'(len - 1);
        return (b & ~m) | ((b + COL_W'(k)) & m);
    endfunction

    // Edge-level model: decide suspension, then update as the requirements say.
    always @(posedge clk) begin
        bit               busy, acc, awr;
        logic [COL_W-1:0] acol;
        m_tag = scen_tag;
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
            for (int i = 0; i <= CL; i++) begin m_v[i] = 1'b0; m_d[i] = '0; end
            m_act = 0; m_wr = 0; m_cke_lo = 0; m_susp = 0;
            m_base = '0; m_cur = '0; m_len = 1; m_idx = 0;
        end else begin
            busy = m_act;
            for (int i = 0; i <= CL; i++) busy = busy | m_v[i];
            m_susp = m_cke_lo && busy;
            if (!m_susp) begin
                for (int i = CL; i > 0; i--) begin m_v[i] = m_v[i-1]; m_d[i] = m_d[i-1]; end
                m_v[0] = 1'b0; m_d[0] = '0;
                acc = 0; awr = 0; acol = '0;
                if (cmd == 2'b01 || cmd == 2'b10) begin
                    acc = 1; acol = col; awr = (cmd == 2'b10);
                    m_base = col; m_len = 1 << bl_sel; m_idx = 1;
                    m_act = (m_len > 1); m_wr = awr;
                end else if (m_act) begin
                    acc = 1; acol = wrap_col(m_base, m_idx, m_len); awr = m_wr;
                    m_idx++;
                    if (m_idx == m_len) m_act = 0;
                end
                if (acc) begin
                    m_cur = acol;
                    if (awr) m_mem[acol] = wdata;
                    else begin m_v[0] = 1'b1; m_d[0] = m_mem[acol]; end
                end
            end
            m_cke_lo = !cke;
        end
    end

    // Compare outputs with the model away from the active edge.
    always @(negedge clk) begin
        string t;
        if (run_cmp && rst_n) begin
            t = m_susp ? "R6" : m_tag;
            chk(cur_col == m_cur, t, "cur_col", cur_col, m_cur);
            chk(rvalid == m_v[CL], t, "rvalid", rvalid, m_v[CL]);
            chk(rdata == m_d[CL], t, "rdata", rdata, m_d[CL]);
        end
        if (rvalid && cap_n < 64) begin
            cap[cap_n] = rdata;
            cap_n++;
        end
    end

    // Watchdog: a hung run is a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    task automatic drv(input logic k, input logic [1:0] c, input int cl,
                       input int wd, input logic [1:0] b);
        @(negedge clk);
        cke = k; cmd = c; col = COL_W'(cl); wdata = DW'(wd); bl_sel = b;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drv(1'b1, 2'b00, 0, 0, 2'b00);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // Reset.
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rvalid == 1'b0, "R1", "rvalid", rvalid, 0);
        chk(rdata == '0, "R1", "rdata", rdata, 0);
        chk(cur_col == '0, "R1", "cur_col", cur_col, 0);
        run_cmp = 1'b1;

        // R1: fresh array reads zero.
        cap_n = 0;
        drv(1'b1, 2'b01, 8, 0, 2'b11); idle(12);
        chk(cap_n == 8, "R2", "beats_bl8", cap_n, 8);
        for (int i = 0; i < 8; i++) chk(cap[i] == '0, "R1", "array_zero", cap[i], 0);

        // R4 / R3: write 4 beats at column 5, read back from column 4.
        scen_tag = "R4";
        drv(1'b1, 2'b10, 5, 'hA0, 2'b10);
        drv(1'b1, 2'b00, 0, 'hA1, 2'b00);
        drv(1'b1, 2'b00, 0, 'hA2, 2'b00);
        drv(1'b1, 2'b00, 0, 'hA3, 2'b00);
        idle(2);
        scen_tag = "R3";
        cap_n = 0;
        drv(1'b1, 2'b01, 4, 0, 2'b10); idle(8);
        chk(cap_n == 4, "R2", "beats_bl4", cap_n, 4);
        chk(cap[0] == 8'hA3, "R3", "beat0_col4", cap[0], 'hA3);
        chk(cap[1] == 8'hA0, "R3", "beat1_col5", cap[1], 'hA0);
        chk(cap[2] == 8'hA1, "R3", "beat2_col6", cap[2], 'hA1);
        chk(cap[3] == 8'hA2, "R4", "beat3_col7", cap[3], 'hA2);

        // R2: lengths 1 and 2.
        scen_tag = "R2";
        cap_n = 0;
        drv(1'b1, 2'b01, 5, 0, 2'b00); idle(6);
        chk(cap_n == 1, "R2", "beats_bl1", cap_n, 1);
        cap_n = 0;
        drv(1'b1, 2'b01, 7, 0, 2'b01); idle(6);
        chk(cap_n == 2, "R2", "beats_bl2", cap_n, 2);
        chk(cap[1] == 8'hA2 && cap[0] == 8'hA3 || cap[0] == 8'hA2, "R3", "bl2_wrap", cap[0], 'hA2);

        // R7: suspended edge drops a stray WRITE and its data.
        scen_tag = "R7";
        drv(1'b0, 2'b10, 12, 'hB0, 2'b10);
        drv(1'b1, 2'b10, 0, 'hFF, 2'b00);
        drv(1'b1, 2'b00, 0, 'hB1, 2'b00);
        drv(1'b1, 2'b00, 0, 'hB2, 2'b00);
        drv(1'b1, 2'b00, 0, 'hB3, 2'b00);
        idle(2);
        cap_n = 0;
        drv(1'b1, 2'b01, 12, 0, 2'b10); idle(8);
        chk(cap_n == 4, "R7", "beats", cap_n, 4);
        chk(cap[0] == 8'hB0, "R7", "col12", cap[0], 'hB0);
        chk(cap[1] == 8'hB1, "R7", "col13", cap[1], 'hB1);
        chk(cap[2] == 8'hB2, "R7", "col14", cap[2], 'hB2);
        chk(cap[3] == 8'hB3, "R7", "col15", cap[3], 'hB3);
        cap_n = 0;
        drv(1'b1, 2'b01, 0, 0, 2'b00); idle(6);
        chk(cap_n == 1 && cap[0] == '0, "R7", "col0_untouched", cap[0], 0);

        // R6 / R9: low pulses inside a read burst, then resume.
        scen_tag = "R9";
        drv(1'b1, 2'b01, 12, 0, 2'b10);
        drv(1'b0, 2'b00, 0, 0, 2'b00);
        drv(1'b0, 2'b01, 3, 0, 2'b00);
        drv(1'b1, 2'b00, 0, 0, 2'b00);
        drv(1'b0, 2'b00, 0, 0, 2'b00);
        drv(1'b1, 2'b00, 0, 0, 2'b00);
        drv(1'b0, 2'b00, 0, 0, 2'b00);
        drv(1'b1, 2'b00, 0, 0, 2'b00);
        idle(8);

        // R8: cke low while idle does not block a command.
        scen_tag = "R8";
        drv(1'b0, 2'b00, 0, 0, 2'b00);
        drv(1'b1, 2'b01, 3, 0, 2'b00);
        @(negedge clk);
        chk(cur_col == 4'd3, "R8", "cur_col", cur_col, 3);
        idle(5);

        // R10: new command cuts a burst short.
        scen_tag = "R10";
        drv(1'b1, 2'b01, 0, 0, 2'b11);
        drv(1'b1, 2'b00, 0, 0, 2'b00);
        drv(1'b1, 2'b01, 9, 0, 2'b00);
        @(negedge clk);
        chk(cur_col == 4'd9, "R10", "cur_col", cur_col, 9);
        idle(6);

        // Random mix.
        scen_tag = "R5";
        for (int n = 0; n < 3000; n++) begin
            int r;
            logic [1:0] c;
            r = $urandom % 8;
            c = (r == 0) ? 2'b01 : (r == 1) ? 2'b10 : (r == 2) ? 2'b11 : 2'b00;
            drv(($urandom % 10) >= 3, c, $urandom % DEPTH, $urandom % 256,
                2'($urandom % 4));
        end
        idle(8);
        run_cmp = 1'b0;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule